// File: doc/BRIEF.md
# Level-Priority Bus Arbiter with Per-Requester Fairness

This block is the central grant point for a shared bus with up to sixteen device requesters and one host processor. Each device presents a request line, a programmable numeric arbitration level and a fairness-enable bit. While the bus is idle, the block compares the levels of the eligible requesters. It registers a one-hot grant to the requester with the lowest numeric level and reports that level beside the grant. The owner keeps the bus until it drops its request. The next owner is chosen in the idle cycle that follows the release.

Fairness keeps a device from being locked out. A device with fairness enabled is marked as served once it wins, and it is then passed over until no unserved request is pending. At that point every mark clears and a new round begins. A device with fairness disabled is never marked, so it can win again as soon as it re-requests.

The host processor has its own request and grant. It outranks every device level. Two requesting devices that carry the same level raise a conflict flag, and no device grant is issued while the flag stands.

Top module: `bus_arbiter_fair`

## Requirements
- R1: At most one of the device grants and the host grant is high in any cycle.
- R2: When the bus is idle, no conflict is present and the host is not requesting, the grant becomes valid at the next clock edge. It goes to the eligible device whose level field `dev_level[i*LVL_W +: LVL_W]` has the smallest value. `grant_level` then holds that value.
- R3: A granted owner keeps its grant for as long as its request stays high, whatever other requests arrive. At the first edge at which its request is low, the grant clears and one idle cycle follows. The next grant is registered at the edge after that.
- R4: `conflict` is high, with no clock delay, whenever two devices with their request high have equal level fields.
- R5: While `conflict` is high and the bus is idle, no device grant is issued. A grant follows once the levels have been reprogrammed so that they differ.
- R6: The host outranks every device. When the bus is idle and `host_req` is high, `host_grant` rises at the next edge even during a conflict, with `dev_grant` all zero and `grant_level` zero. The host keeps the bus until `host_req` falls, and it does not pre-empt a device owner.
- R7: A device with fairness enabled (`dev_fair[i]`=1) that has been granted is not eligible again until no requesting device is eligible. At that point all served marks clear and every requester is eligible again.
- R8: A device with fairness disabled is always eligible, so it wins every arbitration it requests in which it has the smallest level.
- R9: After reset there is no grant, `grant_level` is zero and every served mark is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_REQ | Device request lines |
| dev_level | input | N_REQ*LVL_W | Packed levels, device i at bits i*LVL_W upward; lower value wins |
| dev_fair | input | N_REQ | Per-device fairness enable |
| host_req | input | 1 | Host processor request |
| dev_grant | output | N_REQ | One-hot device grant |
| host_grant | output | 1 | Host grant |
| grant_level | output | LVL_W | Level of the device owning the bus, zero otherwise |
| conflict | output | 1 | Two requesting devices share a level |

## Verification
The host request and a level conflict can be present in the same idle cycle. The host must still be granted while the device grant stays blocked. The bench gives two requesting devices the same level and raises the host request at the same time. It checks for `host_grant` with `conflict` high. After the host releases, it checks that no device grant appears until one level is reprogrammed. A device release and a higher-priority request that is waiting behind the held grant also meet. The bench checks that the waiting device wins only at the second edge after the release.

// File: rtl/arb_fair_pkg.sv
package arb_fair_pkg;

   localparam int ARB_MAX_REQ = 16;

   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_DEV  = 2'd1,
      OWN_HOST = 2'd2
   } arb_owner_e;

endpackage

// File: rtl/lvl_conflict_det.sv
module lvl_conflict_det #(
   parameter int N_REQ = 16,
   parameter int LVL_W = 4
) (
   input  logic [N_REQ-1:0]       req,
   input  logic [N_REQ*LVL_W-1:0] levels,
   output logic                   conflict
);

   localparam int PAIRS = N_REQ * N_REQ;

   logic [PAIRS-1:0] pair_hit;

   // one comparator per unordered pair; diagonal and lower half tied low
   for (genvar gi = 0; gi < N_REQ; gi++) begin : g_row
      for (genvar gj = 0; gj < N_REQ; gj++) begin : g_col
         if (gj > gi) begin : g_cmp
            assign pair_hit[gi*N_REQ+gj] = req[gi] && req[gj] &&
               (levels[gi*LVL_W +: LVL_W] == levels[gj*LVL_W +: LVL_W]);
         end else begin : g_tie
            assign pair_hit[gi*N_REQ+gj] = 1'b0;
         end
      end
   end

   assign conflict = |pair_hit;

endmodule

// File: rtl/lvl_min_pick.sv
module lvl_min_pick #(
   parameter int N_REQ = 16,
   parameter int LVL_W = 4
) (
   input  logic [N_REQ-1:0]       elig,
   input  logic [N_REQ*LVL_W-1:0] levels,
   output logic [N_REQ-1:0]       win,
   output logic [LVL_W-1:0]       win_lvl,
   output logic                   any
);

   always_comb begin
      win     = '0;
      win_lvl = '0;
      any     = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         if (elig[i] && (!any || (levels[i*LVL_W +: LVL_W] < win_lvl))) begin
            win     = '0;
            win[i]  = 1'b1;
            win_lvl = levels[i*LVL_W +: LVL_W];
            any     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fair_round_mask.sv
module fair_round_mask #(
   parameter int N_REQ = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic [N_REQ-1:0] fair,
   input  logic [N_REQ-1:0] take,
   input  logic             take_valid,
   output logic [N_REQ-1:0] elig,
   output logic             new_round
);

   logic [N_REQ-1:0] served_q;
   logic [N_REQ-1:0] unmasked;

   assign unmasked  = req & ~(served_q & fair);
   assign new_round = (unmasked == '0);
   assign elig      = new_round ? req : unmasked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         served_q <= '0;
      end else if (take_valid) begin
         served_q <= (new_round ? '0 : served_q) | (take & fair);
      end
   end

   // R7
   served_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && !new_round) |-> ((take & served_q & fair) == '0));

   // R9
   served_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (served_q == '0));

endmodule

// File: rtl/bus_arbiter_fair.sv
module bus_arbiter_fair
   import arb_fair_pkg::*;
#(
   parameter int N_REQ = 16,
   parameter int LVL_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_REQ-1:0]       dev_req,
   input  logic [N_REQ*LVL_W-1:0] dev_level,
   input  logic [N_REQ-1:0]       dev_fair,
   input  logic                   host_req,
   output logic [N_REQ-1:0]       dev_grant,
   output logic                   host_grant,
   output logic [LVL_W-1:0]       grant_level,
   output logic                   conflict
);

   if (N_REQ < 2 || N_REQ > ARB_MAX_REQ) begin : g_bad_count
      initial $fatal(1, "N_REQ out of range");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_width
      initial $fatal(1, "LVL_W out of range");
   end

   arb_owner_e       owner_q;
   logic [N_REQ-1:0] grant_q;
   logic [LVL_W-1:0] lvl_q;

   logic [N_REQ-1:0] elig;
   logic [N_REQ-1:0] win;
   logic [LVL_W-1:0] win_lvl;
   logic             win_any;
   logic             new_round;
   logic             idle;
   logic             take_dev;
   logic             owner_keeps;

   lvl_conflict_det #(.N_REQ(N_REQ), .LVL_W(LVL_W)) conf_i (
      .req      (dev_req),
      .levels   (dev_level),
      .conflict (conflict)
   );

   fair_round_mask #(.N_REQ(N_REQ)) mask_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (dev_req),
      .fair       (dev_fair),
      .take       (win),
      .take_valid (take_dev),
      .elig       (elig),
      .new_round  (new_round)
   );

   lvl_min_pick #(.N_REQ(N_REQ), .LVL_W(LVL_W)) pick_i (
      .elig    (elig),
      .levels  (dev_level),
      .win     (win),
      .win_lvl (win_lvl),
      .any     (win_any)
   );

   assign idle        = (owner_q == OWN_IDLE);
   assign take_dev    = idle && !host_req && win_any && !conflict;
   assign owner_keeps = |(grant_q & dev_req);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
         grant_q <= '0;
         lvl_q   <= '0;
      end else begin
         unique case (owner_q)
            OWN_IDLE: begin
               if (host_req) begin
                  owner_q <= OWN_HOST;
               end else if (take_dev) begin
                  owner_q <= OWN_DEV;
                  grant_q <= win;
                  lvl_q   <= win_lvl;
               end
            end
            OWN_DEV: begin
               if (!owner_keeps) begin
                  owner_q <= OWN_IDLE;
                  grant_q <= '0;
                  lvl_q   <= '0;
               end
            end
            OWN_HOST: begin
               if (!host_req) owner_q <= OWN_IDLE;
            end
            default: owner_q <= OWN_IDLE;
         endcase
      end
   end

   assign dev_grant   = grant_q;
   assign host_grant  = (owner_q == OWN_HOST);
   assign grant_level = lvl_q;

   // R1
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_grant, host_grant}));

   // R3
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_grant != '0 && |(dev_grant & dev_req)) |=> (dev_grant == $past(dev_grant)));

   // R5
   conflict_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_grant == '0 && !host_grant && conflict) |=> (dev_grant == '0));

   // R6
   host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_grant == '0 && !host_grant && host_req) |=> (host_grant && dev_grant == '0));

   // R6
   host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_grant && !host_req) |=> !host_grant);

endmodule

// File: tb/bus_arbiter_fair_tb.sv
module bus_arbiter_fair_tb_top;

   localparam int NR = 4;
   localparam int LW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NR-1:0]   dev_req = '0;
   logic [NR*LW-1:0] dev_level = '0;
   logic [NR-1:0]   dev_fair = '0;
   logic            host_req = 1'b0;
   logic [NR-1:0]   dev_grant;
   logic            host_grant;
   logic [LW-1:0]   grant_level;
   logic            conflict;

   int n_vec = 0;
   int n_bad = 0;
   logic [NR-1:0] m_srv = '0;

   always #5 clk = ~clk;

   bus_arbiter_fair #(.N_REQ(NR), .LVL_W(LW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_req     (dev_req),
      .dev_level   (dev_level),
      .dev_fair    (dev_fair),
      .host_req    (host_req),
      .dev_grant   (dev_grant),
      .host_grant  (host_grant),
      .grant_level (grant_level),
      .conflict    (conflict)
   );

   task automatic chk(input string rq, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; dev_req = '0; host_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_srv = '0;
      chk("R9 grant", int'(dev_grant), 0);
      chk("R9 host", int'(host_grant), 0);
      chk("R9 level", int'(grant_level), 0);
   endtask

   // one arbitration from idle, judged against an arithmetic model
   task automatic do_round(input logic [NR-1:0] rq, input logic [NR-1:0] fr,
                           input logic [NR*LW-1:0] lv, input string rtag);
      logic [NR-1:0] msk, el, eg;
      logic [LW-1:0] el_l;
      bit cf, nr, fnd;
      dev_req = rq; dev_fair = fr; dev_level = lv; host_req = 1'b0;
      cf = 0;
      for (int i = 0; i < NR; i++)
         for (int j = i + 1; j < NR; j++)
            if (rq[i] && rq[j] && lv[i*LW +: LW] == lv[j*LW +: LW]) cf = 1;
      msk = rq & ~(m_srv & fr);
      nr  = (msk == '0);
      el  = nr ? rq : msk;
      eg = '0; el_l = '0; fnd = 0;
      for (int i = 0; i < NR; i++)
         if (el[i] && (!fnd || lv[i*LW +: LW] < el_l)) begin
            eg = NR'(1 << i); el_l = lv[i*LW +: LW]; fnd = 1;
         end
      if (cf || !fnd) begin eg = '0; el_l = '0; end
      #1;
      chk("R4 conflict", int'(conflict), int'(cf));
      @(negedge clk);
      chk(rtag, int'(dev_grant), int'(eg));
      chk("R2 level", int'(grant_level), int'(el_l));
      chk("R1 host", int'(host_grant), 0);
      if (eg != '0) m_srv = (nr ? '0 : m_srv) | (eg & fr);
      dev_req = '0;
      @(negedge clk);
      chk("R3 release", int'(dev_grant), 0);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [NR*LW-1:0] lv;
      do_reset();

      // R2 R7 R8: sweep all fairness and request patterns over four level maps
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < NR; i++) lv[i*LW +: LW] = LW'((i * 3 + k) % 4);
         for (int f = 0; f < 16; f++)
            for (int r = 0; r < 16; r++)
               do_round(NR'(r), NR'(f), lv, "R2/R7/R8 grant");
      end

      // R4 R5: every pair of levels on two requesters
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++) begin
            lv = '0; lv[0 +: LW] = LW'(a); lv[LW +: LW] = LW'(b);
            do_round(4'b0011, 4'b0000, lv, "R5 grant");
         end

      // R7: two fair requesters alternate
      do_reset();
      lv = '0; lv[0 +: LW] = 3'd0; lv[3*LW +: LW] = 3'd5;
      for (int n = 0; n < 4; n++) begin
         do_round(4'b1001, 4'b1111, lv, "R7 grant");
      end
      do_reset();
      do_round(4'b1001, 4'b1111, lv, "R7 first");
      dev_req = 4'b1001; @(negedge clk); @(negedge clk);
      chk("R7 alternate", int'(dev_grant), 8);
      dev_req = 4'b0000; @(negedge clk);

      // R8: unfair top-priority device keeps winning
      do_reset();
      for (int n = 0; n < 3; n++) begin
         dev_req = 4'b1001; dev_fair = 4'b1000; dev_level = lv;
         @(negedge clk);
         chk("R8 repeat", int'(dev_grant), 1);
         dev_req = 4'b0000; @(negedge clk);
      end

      // R3: hold against a better request, then re-arbitrate after one idle cycle
      do_reset();
      lv = '0; lv[0 +: LW] = 3'd5; lv[LW +: LW] = 3'd1; lv[2*LW +: LW] = 3'd2;
      dev_level = lv; dev_fair = 4'b0000; dev_req = 4'b0001;
      @(negedge clk);
      chk("R3 first", int'(dev_grant), 1);
      dev_req = 4'b0011;
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         chk("R3 hold", int'(dev_grant), 1);
      end
      dev_req = 4'b0010;
      @(negedge clk);
      chk("R3 idle", int'(dev_grant), 0);
      @(negedge clk);
      chk("R3 next", int'(dev_grant), 2);
      chk("R2 level", int'(grant_level), 1);
      dev_req = 4'b0000; @(negedge clk);

      // R6: host waits for device owner, then wins over device requests
      do_reset();
      dev_req = 4'b0001; @(negedge clk);
      host_req = 1'b1; dev_req = 4'b0011;
      @(negedge clk);
      chk("R6 no preempt", int'(host_grant), 0);
      dev_req = 4'b0010;
      @(negedge clk);
      chk("R6 idle", int'(host_grant), 0);
      @(negedge clk);
      chk("R6 host", int'(host_grant), 1);
      chk("R6 devs", int'(dev_grant), 0);
      chk("R6 level", int'(grant_level), 0);
      host_req = 1'b0; dev_req = 4'b0000;
      @(negedge clk); @(negedge clk);

      // R5 R6: host served during a conflict; devices blocked until relevelled
      do_reset();
      lv = '0; lv[0 +: LW] = 3'd2; lv[LW +: LW] = 3'd2;
      dev_level = lv; dev_req = 4'b0011; host_req = 1'b1;
      @(negedge clk);
      chk("R4 flag", int'(conflict), 1);
      chk("R6 host in conflict", int'(host_grant), 1);
      host_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk("R5 blocked", int'(dev_grant), 0);
      chk("R5 host gone", int'(host_grant), 0);
      lv[LW +: LW] = 3'd4; dev_level = lv;
      @(negedge clk);
      chk("R5 relevelled", int'(dev_grant), 1);
      chk("R2 level", int'(grant_level), 2);
      dev_req = 4'b0000; @(negedge clk);

      finish_run();
   end

endmodule